// File: doc/BRIEF.md
# Combinational Staged ALU Array

This block is a register-free datapath made of a chain of ALU stages. Each stage carries a bundle of operand lines. The ALUs in a stage take their two operands from that bundle by select fields, and each writes its result onto one destination line of the same bundle. The bundle that leaves a stage is the input of the next stage. The first stage takes its lines from an external operand-forwarding fabric, and the bundle that leaves the last stage goes back to that fabric. Only mutually independent operations share a stage. An operation that needs another operation's result is placed in a later stage.

Every ALU is set by a static configuration word. The word holds an opcode, two source-line selects, a destination-line select and two predicate bits. Lane 0 of a stage can be marked as that stage's branch slot. Its compare result is then reported to the context controller, and it becomes the condition that predicated ALUs in later stages test. This lets short forward branches be absorbed inside the array. The last lane of a stage can be marked as the memory slot. Its result is then presented as an address together with a store-data value, and it writes no line. The block has no clock and no state.

Top module: `salu_array`

## Requirements
- R1: Every output is a pure combinational function of the present inputs. The block has no clock, no reset and no storage.
- R2: The 4-bit opcode selects the operation on operands a and b. The codes are: 0 a+b, 1 a-b, 2 a AND b, 3 a OR b, 4 a XOR b, 5 a shifted left by b[log2(DATA_W)-1:0], 6 a shifted right logically by the same amount, 7 one if a is less than b as signed numbers and zero otherwise, 8 pass a.
- R3: Each lane has a 15-bit config word {op[14:11], src_a[10:8], src_b[7:5], dst[4:2], pred_en[1], pred_sense[0]}. The word for stage s, lane l sits at alu_cfg_i[(s*LANES+l)*15 +: 15]. Operand line k occupies bits [k*DATA_W +: DATA_W] of a line bus. Operands are read from the stage's incoming lines. A line that no executing ALU writes leaves the stage unchanged.
- R4: Stage s+1 reads the lines produced by stage s, and lines_o carries the lines produced by the last stage.
- R5: When two executing ALUs of one stage write the same destination line, the higher-numbered lane wins.
- R6: An ALU with pred_en=0 always executes. An ALU with pred_en=1 executes only when the current condition equals pred_sense. A failed ALU leaves its destination line unchanged. The condition is 0 on entry to stage 0.
- R7: When stg_br_i[s] is set, lane 0 of stage s writes no line. br_taken_o[s] is then 1 when that lane executes and its result is nonzero, and the condition seen by later stages becomes br_taken_o[s]. br_taken_o[s] is 0 in an unmarked stage, and such a stage passes the condition through unchanged.
- R8: When stg_mem_i[s] is set, the last lane of stage s writes no line and mem_en_o[s] equals that lane's execute decision. mem_addr_o[s] carries the lane's result and mem_wdata_o[s] carries the incoming line named by its dst field. All three outputs are zero when the slot is not enabled.
- R9: Opcodes 9 to 15 produce zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lines_i | input | 8*DATA_W | Operand lines from the forwarding fabric |
| alu_cfg_i | input | STAGES*LANES*15 | Static config words, one per ALU |
| stg_br_i | input | STAGES | Marks lane 0 of a stage as its branch slot |
| stg_mem_i | input | STAGES | Marks the last lane of a stage as its memory slot |
| lines_o | output | 8*DATA_W | Lines after the last stage, back to the fabric |
| br_taken_o | output | STAGES | Branch outcome of each marked stage |
| mem_en_o | output | STAGES | Memory slot of the stage executed |
| mem_addr_o | output | STAGES*DATA_W | Address per stage |
| mem_wdata_o | output | STAGES*DATA_W | Store data per stage |

## Verification
Within a single stage, the branch slot in lane 0 and the memory slot in the last lane can both be active at once. A predicated store in a later stage then depends on that same branch outcome. The bench sets both marks on one stage, places predicated lanes of both senses in the next stages, and drives equal and unequal compare operands so that each outcome is taken. A behavioural model in the bench judges every line, flag, enable, address and data word. Random configurations, in which both marks appear together in about one stage in four, cover the remaining mixes.

// File: rtl/salu_pkg.sv
package salu_pkg;

    localparam int LINE_SEL_W = 3;
    localparam int NLINES     = 1 << LINE_SEL_W;
    localparam int OP_W       = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SLT  = 4'd7,
        OP_PASS = 4'd8
    } alu_op_e;

    typedef struct packed {
        alu_op_e               op;
        logic [LINE_SEL_W-1:0] src_a;
        logic [LINE_SEL_W-1:0] src_b;
        logic [LINE_SEL_W-1:0] dst;
        logic                  pred_en;
        logic                  pred_sense;
    } alu_cfg_t;

    localparam int CFG_W = $bits(alu_cfg_t);

    // Execute decision of a lane for the condition entering its stage
    function automatic logic lane_exec(input alu_cfg_t c, input logic cond);
        return !c.pred_en || (c.pred_sense == cond);
    endfunction

endpackage

// File: rtl/salu_alu.sv
module salu_alu
    import salu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int SHW = $clog2(DATA_W);

    logic [SHW-1:0] shamt;
    assign shamt = b_i[SHW-1:0];

    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = a_i + b_i;
            OP_SUB:  res_o = a_i - b_i;
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_SLL:  res_o = a_i << shamt;
            OP_SRL:  res_o = a_i >> shamt;
            OP_SLT:  res_o = ($signed(a_i) < $signed(b_i)) ? DATA_W'(1) : '0;
            OP_PASS: res_o = a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/salu_stage.sv
module salu_stage
    import salu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 5
) (
    input  logic [NLINES-1:0][DATA_W-1:0] lines_i,
    input  alu_cfg_t [LANES-1:0]          cfg_i,
    input  logic                          br_mark_i,
    input  logic                          mem_mark_i,
    input  logic                          cond_i,
    output logic [NLINES-1:0][DATA_W-1:0] lines_o,
    output logic                          br_taken_o,
    output logic                          cond_o,
    output logic                          mem_en_o,
    output logic [DATA_W-1:0]             mem_addr_o,
    output logic [DATA_W-1:0]             mem_wdata_o
);
    localparam int LAST = LANES - 1;

    logic [DATA_W-1:0] res [LANES];
    logic [LANES-1:0]  exec;
    logic [LANES-1:0]  writes;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        salu_alu #(.DATA_W(DATA_W)) i_alu (
            .op_i  (cfg_i[l].op),
            .a_i   (lines_i[cfg_i[l].src_a]),
            .b_i   (lines_i[cfg_i[l].src_b]),
            .res_o (res[l])
        );
        assign exec[l] = lane_exec(cfg_i[l], cond_i);

        // Reserved slots produce side outputs instead of a line write
        if (l == 0) begin : g_br_slot
            assign writes[l] = exec[l] && !br_mark_i;
        end else if (l == LAST) begin : g_mem_slot
            assign writes[l] = exec[l] && !mem_mark_i;
        end else begin : g_plain
            assign writes[l] = exec[l];
        end
    end

    // Ascending lane order: a higher lane overrides a lower one
    always_comb begin
        lines_o = lines_i;
        for (int l = 0; l < LANES; l++) begin
            if (writes[l]) lines_o[cfg_i[l].dst] = res[l];
        end
    end

    assign br_taken_o = br_mark_i && exec[0] && (res[0] != '0);
    assign cond_o     = br_mark_i ? br_taken_o : cond_i;

    assign mem_en_o    = mem_mark_i && exec[LAST];
    assign mem_addr_o  = mem_en_o ? res[LAST] : '0;
    assign mem_wdata_o = mem_en_o ? lines_i[cfg_i[LAST].dst] : '0;
endmodule

// File: rtl/salu_array.sv
module salu_array
    import salu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 5,
    parameter int STAGES = 4
) (
    input  logic [NLINES*DATA_W-1:0]      lines_i,
    input  logic [STAGES*LANES*CFG_W-1:0] alu_cfg_i,
    input  logic [STAGES-1:0]             stg_br_i,
    input  logic [STAGES-1:0]             stg_mem_i,
    output logic [NLINES*DATA_W-1:0]      lines_o,
    output logic [STAGES-1:0]             br_taken_o,
    output logic [STAGES-1:0]             mem_en_o,
    output logic [STAGES*DATA_W-1:0]      mem_addr_o,
    output logic [STAGES*DATA_W-1:0]      mem_wdata_o
);
    localparam int STG_CFG_W = LANES * CFG_W;

    if (LANES < 2) begin : g_bad_lanes
        $error("salu_array needs at least two lanes per stage");
    end

    logic [NLINES-1:0][DATA_W-1:0] bus [STAGES+1];
    logic [STAGES:0]               cond;

    assign bus[0]  = lines_i;
    assign cond[0] = 1'b0;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        salu_stage #(.DATA_W(DATA_W), .LANES(LANES)) i_stage (
            .lines_i     (bus[s]),
            .cfg_i       (alu_cfg_i[s*STG_CFG_W +: STG_CFG_W]),
            .br_mark_i   (stg_br_i[s]),
            .mem_mark_i  (stg_mem_i[s]),
            .cond_i      (cond[s]),
            .lines_o     (bus[s+1]),
            .br_taken_o  (br_taken_o[s]),
            .cond_o      (cond[s+1]),
            .mem_en_o    (mem_en_o[s]),
            .mem_addr_o  (mem_addr_o[s*DATA_W +: DATA_W]),
            .mem_wdata_o (mem_wdata_o[s*DATA_W +: DATA_W])
        );
    end

    assign lines_o = bus[STAGES];
endmodule

// File: rtl/salu_array_chk.sv
module salu_array_chk
    import salu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 5,
    parameter int STAGES = 4
) (
    input logic [NLINES*DATA_W-1:0]      lines_i,
    input logic [STAGES*LANES*CFG_W-1:0] alu_cfg_i,
    input logic [STAGES-1:0]             stg_br_i,
    input logic [STAGES-1:0]             stg_mem_i,
    input logic [NLINES*DATA_W-1:0]      lines_o,
    input logic [STAGES-1:0]             br_taken_o,
    input logic [STAGES-1:0]             mem_en_o,
    input logic [STAGES*DATA_W-1:0]      mem_addr_o,
    input logic [STAGES*DATA_W-1:0]      mem_wdata_o
);
    alu_cfg_t cw [STAGES*LANES];
    for (genvar i = 0; i < STAGES*LANES; i++) begin : g_dec
        assign cw[i] = alu_cfg_t'(alu_cfg_i[i*CFG_W +: CFG_W]);
    end

    for (genvar k = 0; k < NLINES; k++) begin : g_line
        logic named;
        always_comb begin
            named = 1'b0;
            for (int i = 0; i < STAGES*LANES; i++) begin
                if (cw[i].dst == LINE_SEL_W'(k)) named = 1'b1;
            end
        end
        // R3
        always_comb begin
            untouched_line_chk: assert (named ||
                lines_o[k*DATA_W +: DATA_W] == lines_i[k*DATA_W +: DATA_W])
                else $error("line %0d changed with no writer", k);
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        // R7
        always_comb begin
            br_only_marked_chk: assert (!br_taken_o[s] || stg_br_i[s])
                else $error("stage %0d branch flag without mark", s);
        end
        // R8
        always_comb begin
            mem_only_marked_chk: assert (!mem_en_o[s] || stg_mem_i[s])
                else $error("stage %0d memory enable without mark", s);
        end
        // R8
        always_comb begin
            mem_idle_zero_chk: assert (mem_en_o[s] ||
                (mem_addr_o[s*DATA_W +: DATA_W] == '0 &&
                 mem_wdata_o[s*DATA_W +: DATA_W] == '0))
                else $error("stage %0d memory outputs nonzero while idle", s);
        end
        // R8
        always_comb begin
            mem_unpred_en_chk: assert (!(stg_mem_i[s] && !cw[s*LANES+LANES-1].pred_en)
                                       || mem_en_o[s])
                else $error("stage %0d unpredicated memory slot not enabled", s);
        end
    end

    // R7
    always_comb begin
        pass_branch_chk: assert (!(stg_br_i[0] && cw[0].op == OP_PASS && !cw[0].pred_en)
            || br_taken_o[0] == (lines_i[cw[0].src_a*DATA_W +: DATA_W] != '0))
            else $error("stage 0 pass branch flag mismatch");
    end
endmodule

bind salu_array salu_array_chk #(
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .STAGES (STAGES)
) i_salu_array_chk (
    .lines_i     (lines_i),
    .alu_cfg_i   (alu_cfg_i),
    .stg_br_i    (stg_br_i),
    .stg_mem_i   (stg_mem_i),
    .lines_o     (lines_o),
    .br_taken_o  (br_taken_o),
    .mem_en_o    (mem_en_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
);

// File: tb/test_salu_array.sv
module test_salu_array;
    localparam int DW = 32;
    localparam int LN = 5;
    localparam int ST = 4;
    localparam int NL = 8;
    localparam int CW = 15;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [NL*DW-1:0]    d_lines;
    logic [ST*LN*CW-1:0] d_cfg;
    logic [ST-1:0]       d_br, d_mem;
    logic [NL*DW-1:0]    lines_o;
    logic [ST-1:0]       br_taken_o, mem_en_o;
    logic [ST*DW-1:0]    mem_addr_o, mem_wdata_o;

    salu_array i_salu_array (
        .lines_i(d_lines), .alu_cfg_i(d_cfg), .stg_br_i(d_br), .stg_mem_i(d_mem),
        .lines_o(lines_o), .br_taken_o(br_taken_o), .mem_en_o(mem_en_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    // staged stimulus and expected values
    logic [NL*DW-1:0]    s_lines;
    logic [ST*LN*CW-1:0] s_cfg;
    logic [ST-1:0]       s_br, s_mem;
    logic [NL*DW-1:0]    e_lines;
    logic [ST-1:0]       e_br, e_men;
    logic [ST*DW-1:0]    e_addr, e_wd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic [31:0] ref_op(input logic [3:0] op, input logic [31:0] a, b);
        case (op)
            4'd0: return a + b;
            4'd1: return a - b;
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << b[4:0];
            4'd6: return a >> b[4:0];
            4'd7: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd8: return a;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model();
        logic [31:0] ln [NL];
        logic [31:0] nx [NL];
        logic c;
        c = 1'b0;
        e_br = '0; e_men = '0; e_addr = '0; e_wd = '0;
        for (int k = 0; k < NL; k++) ln[k] = s_lines[k*DW +: DW];
        for (int s = 0; s < ST; s++) begin
            logic flag;
            flag = 1'b0;
            for (int k = 0; k < NL; k++) nx[k] = ln[k];
            for (int l = 0; l < LN; l++) begin
                logic [14:0] w;
                logic ex;
                logic [31:0] r;
                w  = s_cfg[(s*LN+l)*CW +: CW];
                ex = !w[1] || (w[0] == c);
                r  = ref_op(w[14:11], ln[w[10:8]], ln[w[7:5]]);
                if (l == 0 && s_br[s]) begin
                    flag = ex && (r != 0);
                end else if (l == LN-1 && s_mem[s]) begin
                    e_men[s] = ex;
                    e_addr[s*DW +: DW] = ex ? r : 32'd0;
                    e_wd[s*DW +: DW]   = ex ? ln[w[4:2]] : 32'd0;
                end else if (ex) begin
                    nx[w[4:2]] = r;
                end
            end
            e_br[s] = s_br[s] && flag;
            if (s_br[s]) c = flag;
            for (int k = 0; k < NL; k++) ln[k] = nx[k];
        end
        for (int k = 0; k < NL; k++) e_lines[k*DW +: DW] = ln[k];
    endtask

    task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic put(input int s, l, input logic [3:0] op, input logic [2:0] a, b, d,
                       input logic pe, ps);
        s_cfg[(s*LN+l)*CW +: CW] = {op, a, b, d, pe, ps};
    endtask

    task automatic idle();
        for (int s = 0; s < ST; s++)
            for (int l = 0; l < LN; l++) put(s, l, 4'd8, 3'd0, 3'd0, 3'd0, 1'b1, 1'b1);
        s_br = '0; s_mem = '0;
    endtask

    task automatic set_line(input int k, input logic [31:0] v);
        s_lines[k*DW +: DW] = v;
    endtask

    function automatic logic [31:0] out_line(input int k);
        return lines_o[k*DW +: DW];
    endfunction

    task automatic go();
        @(posedge clk);
        d_lines = s_lines; d_cfg = s_cfg; d_br = s_br; d_mem = s_mem;
        model();
        @(negedge clk);
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " lines"}, 256'(lines_o), 256'(e_lines));
        chk({tag, " br"},    256'(br_taken_o), 256'(e_br));
        chk({tag, " men"},   256'(mem_en_o), 256'(e_men));
        chk({tag, " addr"},  256'(mem_addr_o), 256'(e_addr));
        chk({tag, " wdata"}, 256'(mem_wdata_o), 256'(e_wd));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        d_lines = '0; d_cfg = '0; d_br = '0; d_mem = '0;
        for (int k = 0; k < NL; k++) s_lines[k*DW +: DW] = 32'h1111_0000 * k + 32'h55;

        // R1 R6 R3: all lanes predicated off, no marks: lines pass straight through
        idle(); go();
        chk("R6 idle passthrough", 256'(lines_o), 256'(s_lines));
        chk("R7 idle br", 256'(br_taken_o), 256'(0));
        chk("R8 idle mem", 256'({mem_en_o, mem_addr_o}), 256'(0));

        // R2 R9: every opcode in lane 1 of stage 0
        set_line(1, 32'hFFFF_FFF9); set_line(2, 32'd3);
        for (int op = 0; op < 16; op++) begin
            idle(); put(0, 1, 4'(op), 3'd1, 3'd2, 3'd3, 1'b0, 1'b0);
            go();
            chk($sformatf("R2 op %0d", op), 256'(lines_o), 256'(e_lines));
            if (op == 0) chk("R2 add literal", 256'(out_line(3)), 256'(32'hFFFF_FFFC));
            if (op == 7) chk("R2 slt literal", 256'(out_line(3)), 256'(1));
            if (op >= 9) chk("R9 undefined zero", 256'(out_line(3)), 256'(0));
        end

        // R4: dependency chain across stages
        idle();
        set_line(0, 32'd10); set_line(1, 32'd20); set_line(2, 32'd5);
        put(0, 2, 4'd0, 3'd0, 3'd1, 3'd4, 1'b0, 1'b0);
        put(1, 0, 4'd1, 3'd4, 3'd2, 3'd5, 1'b0, 1'b0);
        put(3, 4, 4'd4, 3'd5, 3'd0, 3'd6, 1'b0, 1'b0);
        go();
        chk("R4 chain line5", 256'(out_line(5)), 256'(32'd25));
        chk("R4 chain line6", 256'(out_line(6)), 256'(32'd19));
        chk_all("R4 chain");

        // R5: two lanes write one line, higher lane wins
        idle();
        put(0, 1, 4'd8, 3'd0, 3'd0, 3'd7, 1'b0, 1'b0);
        put(0, 3, 4'd8, 3'd1, 3'd0, 3'd7, 1'b0, 1'b0);
        go();
        chk("R5 higher lane wins", 256'(out_line(7)), 256'(32'd20));

        // R6 R7: branch in stage 0, predicated lanes of both senses in stage 2
        for (int t = 0; t < 2; t++) begin
            idle();
            set_line(0, 32'd9); set_line(1, t ? 32'd9 : 32'd4);
            set_line(2, 32'hAAAA); set_line(3, 32'hBBBB);
            set_line(6, 32'h6666); set_line(7, 32'h7777);
            s_br[0] = 1'b1;
            put(0, 0, 4'd1, 3'd0, 3'd1, 3'd0, 1'b0, 1'b0);
            put(2, 1, 4'd8, 3'd2, 3'd0, 3'd6, 1'b1, 1'b1);
            put(2, 2, 4'd8, 3'd3, 3'd0, 3'd7, 1'b1, 1'b0);
            go();
            chk("R7 br flag", 256'(br_taken_o), 256'(t ? 4'b0000 : 4'b0001));
            chk("R7 br slot no write", 256'(out_line(0)), 256'(32'd9));
            chk("R6 sense1 lane", 256'(out_line(6)), 256'(t ? 32'h6666 : 32'hAAAA));
            chk("R6 sense0 lane", 256'(out_line(7)), 256'(t ? 32'hBBBB : 32'h7777));
        end

        // R7: a later branch stage replaces the condition
        idle();
        set_line(0, 32'd1); set_line(5, 32'd0);
        s_br[0] = 1'b1; s_br[1] = 1'b1;
        put(0, 0, 4'd8, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1, 0, 4'd8, 3'd5, 3'd0, 3'd0, 1'b0, 1'b0);
        put(2, 3, 4'd8, 3'd0, 3'd0, 3'd4, 1'b1, 1'b0);
        go();
        chk("R7 override flags", 256'(br_taken_o), 256'(4'b0001));
        chk("R7 override cond", 256'(out_line(4)), 256'(32'd1));

        // R8: memory slot enabled, then predicated away
        for (int t = 0; t < 2; t++) begin
            idle();
            set_line(0, 32'h100); set_line(1, 32'h24); set_line(2, 32'hD00D);
            s_mem[1] = 1'b1;
            put(1, 4, 4'd0, 3'd0, 3'd1, 3'd2, t[0], 1'b1);
            go();
            chk("R8 men", 256'(mem_en_o), 256'(t ? 4'b0000 : 4'b0010));
            chk("R8 addr", 256'(mem_addr_o), 256'(t ? 0 : {32'h124, 32'h0}));
            chk("R8 wdata", 256'(mem_wdata_o), 256'(t ? 0 : {32'hD00D, 32'h0}));
            chk("R8 no line write", 256'(out_line(2)), 256'(32'hD00D));
        end

        // R7 R8 R6: branch and store in one stage, predicated store next stage
        for (int t = 0; t < 2; t++) begin
            idle();
            set_line(0, 32'd3); set_line(1, t ? 32'd3 : 32'd8); set_line(2, 32'hC0DE);
            s_br[0] = 1'b1; s_mem[0] = 1'b1; s_mem[1] = 1'b1;
            put(0, 0, 4'd4, 3'd0, 3'd1, 3'd0, 1'b0, 1'b0);
            put(0, 4, 4'd0, 3'd0, 3'd0, 3'd2, 1'b1, 1'b0);
            put(1, 4, 4'd0, 3'd1, 3'd1, 3'd2, 1'b1, 1'b1);
            go();
            chk_all("R7 R8 same stage");
            chk("R8 pred store", 256'(mem_en_o), 256'(t ? 4'b0001 : 4'b0011));
        end

        // R1-style random sweep covering all requirements together
        for (int it = 0; it < 500; it++) begin
            for (int k = 0; k < NL; k++)
                s_lines[k*DW +: DW] = ($urandom % 4 == 0) ? 32'($urandom % 8) : $urandom;
            for (int w = 0; w < ST*LN; w++) s_cfg[w*CW +: CW] = 15'($urandom);
            s_br = 4'($urandom); s_mem = 4'($urandom);
            go();
            chk_all($sformatf("R2 R3 R4 R5 R6 R7 R8 random %0d", it));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule